// File: doc/BRIEF.md
# Two-Word Xorshift-Rotate Random Source with Add-Rotate-Add Output

This block is a pseudo-random number source with 64 bits of state held in two 32-bit words. Every clock on which the step input is high it registers one 32-bit random word and moves the state on by one position. The output word is always taken from the state as it stood before that step. This keeps the scrambler and the state update side by side in parallel logic, so neither waits for the other.

The state update is an xorshift with rotates: a rotate of 26 and a shift of 9 feed the first word, and a rotate of 13 feeds the second. The output scrambler is add, rotate by 17, add. Because it mixes bits that well, any single bit of the output may be used alone as a random bit. A second output carries the plain sum of the two words, which is cheaper to compute but is weaker in its low bits. A seed strobe loads both words. The state must never be all zero, so a seed that is zero in both words is swapped for a fixed non-zero default, and reset loads that same default.

Top module: `xr64pp_gen`

## Requirements
- R1: After reset the state equals the default seed (word 0 = 32'h9E3779B9, word 1 = 32'h7F4A7C15), `rnd_valid` is 0, and both `rnd` and `rnd_plus` are 0.
- R2: On a clock edge with `step` high and `seed_load` low, `rnd` takes the value rotl32(w0 + w1, 17) + w0, computed from the state before the edge, with all sums modulo 2^32. It is visible after that edge.
- R3: The same edge advances the state: t = w1 ^ w0, new w0 = rotl32(w0, 26) ^ t ^ (t << 9), new w1 = rotl32(t, 13).
- R4: `rnd_valid` is high in the cycle after every step edge, and low after any edge with `step` low or with `seed_load` high.
- R5: On an edge with `step` low and `seed_load` low, the state, `rnd` and `rnd_plus` are all left unchanged.
- R6: On an edge with `seed_load` high, the state becomes {`seed_w0`, `seed_w1`} and `rnd`/`rnd_plus` are left unchanged. `seed_load` wins over `step` on the same edge.
- R7: A loaded seed with both words zero is replaced by the default seed of R1.
- R8: With `PLUS_OUT` = 1 (default), `rnd_plus` is registered on each step edge as w0 + w1 of the state before the edge. With `PLUS_OUT` = 0 it stays 0.
- R9: The state is never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Produce one word and advance the state |
| seed_load | input | 1 | Load the seed words into the state |
| seed_w0 | input | 32 | Seed for state word 0 |
| seed_w1 | input | 32 | Seed for state word 1 |
| rnd | output | 32 | Scrambled random word |
| rnd_plus | output | 32 | Single-add result w0 + w1 |
| rnd_valid | output | 1 | High the cycle after a step edge |

## Verification
If any state bit goes wrong, every following output word depends on it. A corrupted state therefore shows at `rnd` on the very next step edge, and the error then carries into each word after it. A wrong rotate or shift constant shows up within one or two steps after any seed load. The bench loads fresh random seeds often and compares every stepped word with a model of the recurrence, so a fault in the update is caught no more than a few steps after it starts. A fault in the hold, load-priority or zero-seed paths shows as a wrong next word or a wrong valid flag in the cycle that follows.

// File: rtl/xr_pkg.sv
package xr_pkg;
   localparam int unsigned XR_W = 32;

   typedef struct packed {
      logic [XR_W-1:0] w0;
      logic [XR_W-1:0] w1;
   } xr_state_t;

   function automatic logic [XR_W-1:0] rotl(input logic [XR_W-1:0] v, input int unsigned n);
      return (v << n) | (v >> (XR_W - n));
   endfunction
endpackage

// File: rtl/xr_advance.sv
module xr_advance
   import xr_pkg::*;
#(
   parameter int unsigned ROT_A = 26,
   parameter int unsigned SHL_B = 9,
   parameter int unsigned ROT_C = 13
) (
   input  xr_state_t cur,
   output xr_state_t nxt
);
   generate
      if (ROT_A == 0 || ROT_A >= XR_W) begin : g_bad_a
         $error("xr_advance: ROT_A out of range");
      end
      if (SHL_B == 0 || SHL_B >= XR_W) begin : g_bad_b
         $error("xr_advance: SHL_B out of range");
      end
      if (ROT_C == 0 || ROT_C >= XR_W) begin : g_bad_c
         $error("xr_advance: ROT_C out of range");
      end
   endgenerate

   logic [XR_W-1:0] t;

   always_comb begin
      t      = cur.w1 ^ cur.w0;
      nxt.w0 = rotl(cur.w0, ROT_A) ^ t ^ (t << SHL_B);
      nxt.w1 = rotl(t, ROT_C);
   end
endmodule

// File: rtl/xr_scramble.sv
module xr_scramble
   import xr_pkg::*;
#(
   parameter int unsigned ROT_D    = 17,
   parameter bit          PLUS_OUT = 1'b1
) (
   input  xr_state_t       cur,
   output logic [XR_W-1:0] pp_word,
   output logic [XR_W-1:0] plus_word
);
   generate
      if (ROT_D == 0 || ROT_D >= XR_W) begin : g_bad_d
         $error("xr_scramble: ROT_D out of range");
      end
   endgenerate

   logic [XR_W-1:0] sum;

   always_comb begin
      sum     = cur.w0 + cur.w1;
      pp_word = rotl(sum, ROT_D) + cur.w0;
   end

   generate
      if (PLUS_OUT) begin : g_plus
         assign plus_word = sum;
      end else begin : g_noplus
         assign plus_word = '0;
      end
   endgenerate
endmodule

// File: rtl/xr_seed_fix.sv
module xr_seed_fix
   import xr_pkg::*;
#(
   parameter logic [XR_W-1:0] DEF_W0 = 32'h9E3779B9,
   parameter logic [XR_W-1:0] DEF_W1 = 32'h7F4A7C15
) (
   input  logic [XR_W-1:0] seed_w0,
   input  logic [XR_W-1:0] seed_w1,
   output xr_state_t       fixed
);
   generate
      if (DEF_W0 == '0 && DEF_W1 == '0) begin : g_bad_def
         $error("xr_seed_fix: default seed must be non-zero");
      end
   endgenerate

   always_comb begin
      if (seed_w0 == '0 && seed_w1 == '0) begin
         fixed.w0 = DEF_W0;
         fixed.w1 = DEF_W1;
      end else begin
         fixed.w0 = seed_w0;
         fixed.w1 = seed_w1;
      end
   end
endmodule

// File: rtl/xr64pp_gen.sv
module xr64pp_gen
   import xr_pkg::*;
#(
   parameter int unsigned     ROT_A    = 26,
   parameter int unsigned     SHL_B    = 9,
   parameter int unsigned     ROT_C    = 13,
   parameter int unsigned     ROT_D    = 17,
   parameter bit              PLUS_OUT = 1'b1,
   parameter logic [31:0]     DEF_W0   = 32'h9E3779B9,
   parameter logic [31:0]     DEF_W1   = 32'h7F4A7C15
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        step,
   input  logic        seed_load,
   input  logic [31:0] seed_w0,
   input  logic [31:0] seed_w1,
   output logic [31:0] rnd,
   output logic [31:0] rnd_plus,
   output logic        rnd_valid
);
   xr_state_t       st_q, st_nxt, st_seed;
   logic [XR_W-1:0] pp_w, plus_w;

   xr_advance #(.ROT_A(ROT_A), .SHL_B(SHL_B), .ROT_C(ROT_C)) u_adv (
      .cur (st_q),
      .nxt (st_nxt)
   );

   xr_scramble #(.ROT_D(ROT_D), .PLUS_OUT(PLUS_OUT)) u_scr (
      .cur       (st_q),
      .pp_word   (pp_w),
      .plus_word (plus_w)
   );

   xr_seed_fix #(.DEF_W0(DEF_W0), .DEF_W1(DEF_W1)) u_seed (
      .seed_w0 (seed_w0),
      .seed_w1 (seed_w1),
      .fixed   (st_seed)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q.w0   <= DEF_W0;
         st_q.w1   <= DEF_W1;
         rnd       <= '0;
         rnd_plus  <= '0;
         rnd_valid <= 1'b0;
      end else if (seed_load) begin
         st_q      <= st_seed;
         rnd_valid <= 1'b0;
      end else if (step) begin
         st_q      <= st_nxt;
         rnd       <= pp_w;
         rnd_plus  <= plus_w;
         rnd_valid <= 1'b1;
      end else begin
         rnd_valid <= 1'b0;
      end
   end

   // R9: the state never reaches all zero
   a_r9_state_nonzero: assert property (@(posedge clk) disable iff (rst)
      st_q != '0);

   // R4: a step edge raises valid
   a_r4_valid_after_step: assert property (@(posedge clk) disable iff (rst)
      (step && !seed_load) |=> rnd_valid);

   // R6: a load edge clears valid and keeps the output
   a_r6_load_holds_out: assert property (@(posedge clk) disable iff (rst)
      seed_load |=> (!rnd_valid && $stable(rnd)));

   // R5: an idle edge freezes state and output
   a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
      (!step && !seed_load) |=> ($stable(st_q) && $stable(rnd) && $stable(rnd_plus)));

   // R7: a zero seed lands on the default state
   a_r7_zero_seed: assert property (@(posedge clk) disable iff (rst)
      (seed_load && seed_w0 == '0 && seed_w1 == '0) |=>
         (st_q.w0 == DEF_W0 && st_q.w1 == DEF_W1));
endmodule

// File: tb/sim_xr64pp_gen.sv
module sim_xr64pp_gen;
   localparam logic [31:0] D0 = 32'h9E3779B9;
   localparam logic [31:0] D1 = 32'h7F4A7C15;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        step = 1'b0;
   logic        seed_load = 1'b0;
   logic [31:0] seed_w0 = '0;
   logic [31:0] seed_w1 = '0;
   logic [31:0] rnd, rnd_plus;
   logic        rnd_valid;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   logic [31:0] m0, m1, e_out, e_plus;
   logic        e_valid;

   always #2 clk = ~clk;

   xr64pp_gen u0 (
      .clk(clk), .rst(rst), .step(step), .seed_load(seed_load),
      .seed_w0(seed_w0), .seed_w1(seed_w1),
      .rnd(rnd), .rnd_plus(rnd_plus), .rnd_valid(rnd_valid)
   );

   function automatic logic [31:0] rl(input logic [31:0] v, input int n);
      return (v << n) | (v >> (32 - n));
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic s, input logic ld, input logic [31:0] a, input logic [31:0] b,
                      input string req);
      logic [31:0] t;
      @(negedge clk);
      step = s; seed_load = ld; seed_w0 = a; seed_w1 = b;
      @(posedge clk);
      if (ld) begin
         if (a == 0 && b == 0) begin m0 = D0; m1 = D1; end
         else begin m0 = a; m1 = b; end
         e_valid = 1'b0;
      end else if (s) begin
         e_plus  = m0 + m1;
         e_out   = rl(m0 + m1, 17) + m0;
         t       = m1 ^ m0;
         m0      = rl(m0, 26) ^ t ^ (t << 9);
         m1      = rl(t, 13);
         e_valid = 1'b1;
      end else begin
         e_valid = 1'b0;
      end
      #1;
      check({req, " rnd"}, rnd, e_out);
      check({req, " rnd_plus (R8)"}, rnd_plus, e_plus);
      check({req, " valid (R4)"}, {31'd0, rnd_valid}, {31'd0, e_valid});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m0 = D0; m1 = D1; e_out = 0; e_plus = 0; e_valid = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      // R1: reset values on outputs
      check("R1 rnd", rnd, 32'h0);
      check("R1 rnd_plus", rnd_plus, 32'h0);
      check("R1 valid", {31'd0, rnd_valid}, 32'h0);
      // R1/R2/R3: first words come from the default seed
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 0, 0, "R2 R3 default seed");
      // R5: idle cycles hold everything
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, $urandom, $urandom, "R5 idle hold");
      cyc(1'b1, 1'b0, 0, 0, "R5 resume after idle");
      // R6: load with step high, load wins
      cyc(1'b1, 1'b1, 32'h00000001, 32'h00000000, "R6 load priority");
      cyc(1'b1, 1'b0, 0, 0, "R6 first word after load");
      cyc(1'b1, 1'b0, 0, 0, "R3 sparse seed advance");
      // R7: zero seed gives the default
      cyc(1'b0, 1'b1, 32'h0, 32'h0, "R7 zero seed");
      cyc(1'b1, 1'b0, 0, 0, "R7 word from default");
      // R2: all-ones seed, carry wrap
      cyc(1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, "R6 load ones");
      cyc(1'b1, 1'b0, 0, 0, "R2 modulo wrap");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom_range(0, 15);
         if (r == 0)      cyc($urandom_range(0, 1), 1'b1, $urandom, $urandom, "R6 random load");
         else if (r == 1) cyc(1'b0, 1'b1, 32'h0, 32'h0, "R7 random zero seed");
         else if (r < 5)  cyc(1'b0, 1'b0, $urandom, $urandom, "R5 random idle");
         else             cyc(1'b1, 1'b0, $urandom, $urandom, "R2 R3 random step");
      end
      // R9: long stepped run stays consistent with the nonzero recurrence
      for (int i = 0; i < 500; i++) cyc(1'b1, 1'b0, 0, 0, "R9 long run");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule